// File: doc/BRIEF.md
# Serial Flash Operation Sequencer

This block performs one complete serial-flash command as a single SPI transaction. Chip select is held low for the whole transaction. A host presents a command descriptor together with a one-cycle start pulse. The descriptor holds a command byte, an address of up to four bytes, up to eight dummy bytes, a direction and a data length. The block then shifts out a header made of the command byte, the address bytes and the dummy bytes. After the header it does one of two things. In receive mode it clocks in the requested number of data bytes from the flash. In transmit mode it sends the requested number of payload bytes to the flash and discards everything the flash returns.

Payload moves through two byte-wide valid/ready streams. Transmit bytes enter through a single-byte holding register. Each received byte waits in an output register until the host takes it. The flash can never see a broken frame. If the host is late with a transmit byte, or has not yet taken a received byte, the serial clock pauses with chip select still low. The block never sends a filler byte. SCLK comes from a programmable divider of the system clock. `busy` is high for the whole operation, and a one-cycle `done` pulse ends it.

Top module: `sfl_op_seq`

## Requirements
- R1: The header is sent in this order: the command byte, then the address bytes with the most significant address byte first, then the dummy bytes. Each dummy byte is 0xFF on `mosi`. With N address bytes, header byte i (for 1 <= i <= N) is bits [8(N-i)+7 : 8(N-i)] of `op_addr`.
- R2: An `op_addr_len` above 4 is treated as 4, and an `op_dummy_len` above 8 is treated as 8.
- R3: SPI mode 0 is used. SCLK is low whenever chip select is high. `mosi` changes only while SCLK is low, and it holds steady across every rising edge. Each byte goes out most significant bit first, and `miso` is sampled on the rising edge, MSB first.
- R4: Inside a byte, one SCLK period lasts 2*max(`sck_half`,1) system clock cycles. A `sck_half` of 0 behaves like 1.
- R5: In receive mode (`op_read`=1), exactly `op_len_m1`+1 bytes are clocked in after the header, with `mosi` held at 0. Each byte appears on `rx_data` with `rx_valid` set. It stays unchanged until `rx_ready` is seen high.
- R6: In transmit mode (`op_read`=0), `op_len_m1`+1 bytes are taken from the transmit stream and sent after the header, in arrival order. The first payload byte is taken before chip select falls. `tx_ready` is low whenever `busy` is low.
- R7: Chip select falls once per operation and rises once per operation, and it never rises between bytes. When the next transmit byte is not available, or the previous received byte has not been taken, SCLK stays low and chip select stays low. Exactly (header+payload)*8 SCLK rising edges occur.
- R8: Chip select rises only after the last SCLK falling edge. `done` is high for exactly one cycle, in the cycle after chip select rises. `busy` falls in that same cycle.
- R9: A start pulse that arrives while `busy` is high is ignored. So is any change to the descriptor inputs during an operation. Neither one alters the frame on the wire, and neither one starts a second operation.
- R10: The length field is 16 bits wide, so one operation can carry up to 65536 payload bytes. Lengths above 256 bytes are counted correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | One-cycle pulse that starts an operation when idle |
| op_read | input | 1 | 1: header then receive; 0: header then transmit |
| op_code | input | 8 | Command byte |
| op_addr | input | 32 | Address value |
| op_addr_len | input | 3 | Address byte count (values above 4 clamp to 4) |
| op_dummy_len | input | 4 | Dummy byte count (values above 8 clamp to 8) |
| op_len_m1 | input | 16 | Payload byte count minus one |
| sck_half | input | 8 | SCLK half period in system cycles (0 acts as 1) |
| tx_data | input | 8 | Transmit stream byte |
| tx_valid | input | 1 | Transmit stream valid |
| tx_ready | output | 1 | Transmit stream ready |
| rx_data | output | 8 | Receive stream byte |
| rx_valid | output | 1 | Receive stream valid |
| rx_ready | input | 1 | Receive stream ready |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Two pairs of events can fall in the same cycle. In the first pair, the transmit holding register is emptied into the shifter while the stream loads a new byte into it. In the second pair, the host takes the pending received byte in the very cycle the sequencer decides whether the next receive byte may start. The bench varies the transmit gaps and the `rx_ready` patterns from one operation to the next, so both coincidences occur many times. It judges the outcome on the wire and on the streams: no byte may be lost or repeated, the frame must have exactly the expected number of SCLK edges, and chip select must rise only once. A start pulse with altered descriptor inputs is also injected in the middle of operations. The frame and the single `done` pulse must come out unaffected.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

    localparam int BYTE_W     = 8;
    localparam int BIT_IDX_W  = $clog2(BYTE_W);
    localparam int ADDR_MAX   = 4;
    localparam int DUMMY_MAX  = 8;
    localparam int CNT_W      = 16;
    localparam int ADDR_W     = BYTE_W * ADDR_MAX;
    localparam int NA_W       = $clog2(ADDR_MAX + 1);
    localparam int ND_W       = $clog2(DUMMY_MAX + 1);
    localparam int HDR_MAX    = 1 + ADDR_MAX + DUMMY_MAX;
    localparam int HIDX_W     = $clog2(HDR_MAX + 1);
    localparam int FL_W       = CNT_W + 1;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ISSUE,
        ST_WAIT,
        ST_END,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic              rd;
        byte_t             opc;
        logic [ADDR_W-1:0] addr;
        logic [NA_W-1:0]   na;
        logic [ND_W-1:0]   nd;
    } op_desc_t;

    function automatic logic [NA_W-1:0] clamp_na(input logic [NA_W-1:0] v);
        return (v > NA_W'(ADDR_MAX)) ? NA_W'(ADDR_MAX) : v;
    endfunction

    function automatic logic [ND_W-1:0] clamp_nd(input logic [ND_W-1:0] v);
        return (v > ND_W'(DUMMY_MAX)) ? ND_W'(DUMMY_MAX) : v;
    endfunction

    // Byte sent at header position idx: command, address MSB first, then 0xFF fill.
    function automatic byte_t hdr_byte(input byte_t             opc,
                                       input logic [ADDR_W-1:0] a,
                                       input logic [NA_W-1:0]   na,
                                       input logic [HIDX_W-1:0] idx);
        logic [HIDX_W-1:0] d;
        if (idx == '0) begin
            return opc;
        end
        if (idx <= HIDX_W'(na)) begin
            d = HIDX_W'(na) - idx;
            return byte_t'(a >> {d, 3'b000});
        end
        return '1;
    endfunction

endpackage

// File: rtl/sfl_clkdiv.sv
module sfl_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = (half == '0) ? DIV_W'(1) : half;
    assign tick = run && (cnt == lim - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/sfl_shifter.sv
module sfl_shifter
    import sfl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  byte_t din,
    input  logic  tick,
    input  logic  miso,
    output logic  sclk,
    output logic  mosi,
    output logic  active,
    output logic  byte_done,
    output byte_t rx_byte
);

    byte_t                sh;
    byte_t                rx;
    logic                 hi;
    logic [BIT_IDX_W-1:0] bits;

    assign mosi    = sh[BYTE_W-1];
    assign rx_byte = rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= '0;
            rx        <= '0;
            hi        <= 1'b0;
            bits      <= '0;
            sclk      <= 1'b0;
            active    <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (load) begin
                sh     <= din;
                active <= 1'b1;
                hi     <= 1'b0;
                bits   <= '0;
            end else if (active && tick) begin
                if (!hi) begin
                    sclk <= 1'b1;
                    hi   <= 1'b1;
                    rx   <= {rx[BYTE_W-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    hi   <= 1'b0;
                    if (bits == BIT_IDX_W'(BYTE_W - 1)) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bits <= bits + BIT_IDX_W'(1);
                        sh   <= {sh[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sfl_txhold.sv
module sfl_txhold
    import sfl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  want,
    input  byte_t s_data,
    input  logic  s_valid,
    output logic  s_ready,
    input  logic  pop,
    output logic  hold_valid,
    output byte_t hold_data
);

    logic take;

    assign s_ready = want && (!hold_valid || pop);
    assign take    = s_valid && s_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else if (take) begin
            hold_valid <= 1'b1;
            hold_data  <= s_data;
        end else if (pop) begin
            hold_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/sfl_op_seq.sv
module sfl_op_seq
    import sfl_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    op_start,
    input  logic                    op_read,
    input  logic [BYTE_W-1:0]       op_code,
    input  logic [ADDR_W-1:0]       op_addr,
    input  logic [NA_W-1:0]         op_addr_len,
    input  logic [ND_W-1:0]         op_dummy_len,
    input  logic [CNT_W-1:0]        op_len_m1,
    input  logic [DIV_W-1:0]        sck_half,
    input  logic [BYTE_W-1:0]       tx_data,
    input  logic                    tx_valid,
    output logic                    tx_ready,
    output logic [BYTE_W-1:0]       rx_data,
    output logic                    rx_valid,
    input  logic                    rx_ready,
    output logic                    busy,
    output logic                    done,
    output logic                    cs_n,
    output logic                    sclk,
    output logic                    mosi,
    input  logic                    miso
);

    seq_state_e        st;
    op_desc_t          d;
    logic [HIDX_W-1:0] hidx;
    logic [HIDX_W-1:0] hdr_len;
    logic [CNT_W-1:0]  left;
    logic [FL_W-1:0]   fetch_left;
    logic              cur_data;

    logic  tick;
    logic  sh_load;
    byte_t sh_byte;
    logic  sh_active;
    logic  sh_done;
    byte_t sh_rx;

    logic  want;
    logic  pop;
    logic  hold_v;
    byte_t hold_d;
    logic  tx_take;

    logic  rx_free;
    logic  push;
    logic  in_hdr;

    assign hdr_len = HIDX_W'(1) + HIDX_W'(d.na) + HIDX_W'(d.nd);
    assign in_hdr  = hidx < hdr_len;
    assign want    = busy && !d.rd && (fetch_left != '0);
    assign tx_take = tx_valid && tx_ready;
    assign rx_free = !rx_valid || rx_ready;
    assign push    = (st == ST_WAIT) && sh_done && cur_data && d.rd;

    always_comb begin
        sh_load = 1'b0;
        sh_byte = '0;
        pop     = 1'b0;
        if (st == ST_ISSUE) begin
            if (in_hdr) begin
                sh_load = 1'b1;
                sh_byte = hdr_byte(d.opc, d.addr, d.na, hidx);
            end else if (d.rd) begin
                sh_load = rx_free;
            end else if (hold_v) begin
                sh_load = 1'b1;
                sh_byte = hold_d;
                pop     = 1'b1;
            end
        end
    end

    sfl_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (sh_active),
        .half (sck_half),
        .tick (tick)
    );

    sfl_shifter u_sh (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .din       (sh_byte),
        .tick      (tick),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .active    (sh_active),
        .byte_done (sh_done),
        .rx_byte   (sh_rx)
    );

    sfl_txhold u_hold (
        .clk        (clk),
        .rst        (rst),
        .want       (want),
        .s_data     (tx_data),
        .s_valid    (tx_valid),
        .s_ready    (tx_ready),
        .pop        (pop),
        .hold_valid (hold_v),
        .hold_data  (hold_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            d          <= '0;
            hidx       <= '0;
            left       <= '0;
            fetch_left <= '0;
            cur_data   <= 1'b0;
            cs_n       <= 1'b1;
            busy       <= 1'b0;
            done       <= 1'b0;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
        end else begin
            done <= 1'b0;

            if (tx_take) begin
                fetch_left <= fetch_left - FL_W'(1);
            end

            if (push) begin
                rx_valid <= 1'b1;
                rx_data  <= sh_rx;
            end else if (rx_ready) begin
                rx_valid <= 1'b0;
            end

            case (st)
                ST_IDLE: begin
                    if (op_start) begin
                        d.rd       <= op_read;
                        d.opc      <= op_code;
                        d.addr     <= op_addr;
                        d.na       <= clamp_na(op_addr_len);
                        d.nd       <= clamp_nd(op_dummy_len);
                        hidx       <= '0;
                        left       <= op_len_m1;
                        fetch_left <= FL_W'(op_len_m1) + FL_W'(1);
                        busy       <= 1'b1;
                        if (op_read) begin
                            cs_n <= 1'b0;
                            st   <= ST_ISSUE;
                        end else begin
                            st   <= ST_PRE;
                        end
                    end
                end
                ST_PRE: begin
                    if (hold_v) begin
                        cs_n <= 1'b0;
                        st   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (sh_load) begin
                        st <= ST_WAIT;
                        if (in_hdr) begin
                            hidx     <= hidx + HIDX_W'(1);
                            cur_data <= 1'b0;
                        end else begin
                            cur_data <= 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (sh_done) begin
                        if (cur_data) begin
                            if (left == '0) begin
                                st <= ST_END;
                            end else begin
                                left <= left - CNT_W'(1);
                                st   <= ST_ISSUE;
                            end
                        end else begin
                            st <= ST_ISSUE;
                        end
                    end
                end
                ST_END: begin
                    cs_n <= 1'b1;
                    st   <= ST_FIN;
                end
                ST_FIN: begin
                    done <= 1'b1;
                    busy <= 1'b0;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sfl_op_seq_chk.sv
module sfl_op_seq_chk
    import sfl_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  busy,
    input logic  done,
    input logic  cs_n,
    input logic  sclk,
    input logic  mosi,
    input logic  tx_ready,
    input logic  rx_valid,
    input logic  rx_ready,
    input byte_t rx_data
);

    a_r3_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    a_r3_mosi_steady_while_high: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi));

    a_r7_sclk_moves_only_selected: assert property (@(posedge clk) disable iff (rst)
        !$stable(sclk) |-> !cs_n);

    a_r8_done_follows_release: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> done);

    a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && !busy));

    a_r5_rx_held_until_taken: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    a_r6_no_tx_ready_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tx_ready);

endmodule

bind sfl_op_seq sfl_op_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data)
);

// File: tb/sim_sfl_op_seq.sv
module sim_sfl_op_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NBITS      = 32768;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_start = 1'b0;
    logic        op_read = 1'b0;
    logic [7:0]  op_code = '0;
    logic [31:0] op_addr = '0;
    logic [2:0]  op_addr_len = '0;
    logic [3:0]  op_dummy_len = '0;
    logic [15:0] op_len_m1 = '0;
    logic [7:0]  sck_half = 8'd1;
    logic [7:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_ready = 1'b0;
    logic        busy;
    logic        done;
    logic        cs_n;
    logic        sclk;
    logic        mosi;
    logic        miso;

    int tests = 0;
    int fails = 0;

    int     bitpos = 0;
    int     cs_rises = 0;
    int     done_cnt = 0;
    int     cur_base = 0;
    int     cur_hdr = 1;
    int     cur_seed = 0;
    logic   cap [0:NBITS-1];
    longint rise_t [0:NBITS-1];

    always #(CLK_PERIOD/2) clk = ~clk;

    sfl_op_seq u0 (
        .clk          (clk),
        .rst          (rst),
        .op_start     (op_start),
        .op_read      (op_read),
        .op_code      (op_code),
        .op_addr      (op_addr),
        .op_addr_len  (op_addr_len),
        .op_dummy_len (op_dummy_len),
        .op_len_m1    (op_len_m1),
        .sck_half     (sck_half),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_ready     (rx_ready),
        .busy         (busy),
        .done         (done),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .mosi         (mosi),
        .miso         (miso)
    );

    function automatic logic [7:0] resp_byte(input int j, input int seed);
        return 8'((j * 29 + seed * 3 + 1) & 255);
    endfunction

    function automatic logic [7:0] tx_byte(input int j, input int seed);
        return 8'((j * 53 + seed * 11 + 7) & 255);
    endfunction

    function automatic logic model_bit(input int rel, input int hl, input int seed);
        logic [7:0] v;
        if (rel < 0 || (rel / 8) < hl) return 1'b1;
        v = resp_byte(rel / 8 - hl, seed);
        return v[7 - (rel % 8)];
    endfunction

    assign miso = model_bit(bitpos - cur_base, cur_hdr, cur_seed);

    // Flash-side monitor
    always @(posedge sclk) begin
        if (!cs_n && bitpos < NBITS) begin
            cap[bitpos]    = mosi;
            rise_t[bitpos] = $time;
            bitpos         = bitpos + 1;
        end
    end

    always @(posedge cs_n) cs_rises = cs_rises + 1;

    always @(posedge clk) if (done === 1'b1) done_cnt = done_cnt + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] wire_byte(input int base, input int k);
        logic [7:0] v;
        for (int b = 0; b < 8; b++) v[7-b] = cap[base + 8*k + b];
        return v;
    endfunction

    function automatic logic [7:0] exp_hdr(input int i, input logic [7:0] opc,
                                           input logic [31:0] a, input int abe);
        if (i == 0) return opc;
        if (i <= abe) return 8'((a >> (8 * (abe - i))) & 32'hFF);
        return 8'hFF;
    endfunction

    task automatic run_op(input bit rd, input int ab, input int db, input int last,
                          input int h, input int seed, input bit poke);
        int abe, dbe, hl, n, base, d0, c0, acc, got, hbad, dbad, lim;
        logic [7:0] opc;
        logic [31:0] adr;
        logic [7:0] rxq [0:511];
        abe  = (ab > 4) ? 4 : ab;
        dbe  = (db > 8) ? 8 : db;
        hl   = 1 + abe + dbe;
        n    = last + 1;
        lim  = (h == 0) ? 1 : h;
        opc  = 8'((seed * 13 + 3) & 255);
        adr  = 32'hA1B2C3D4 ^ (32'(seed) * 32'h01030507);
        acc  = 0;
        got  = 0;
        @(negedge clk);
        base     = bitpos;
        cur_base = base;
        cur_hdr  = hl;
        cur_seed = seed;
        d0       = done_cnt;
        c0       = cs_rises;
        op_read      = rd;
        op_code      = opc;
        op_addr      = adr;
        op_addr_len  = 3'(ab);
        op_dummy_len = 4'(db);
        op_len_m1    = 16'(last);
        sck_half     = 8'(h);
        op_start     = 1'b1;
        @(negedge clk);
        op_start     = 1'b0;
        fork
            begin
                if (!rd) begin
                    for (int j = 0; j < n; j++) begin
                        repeat ((j + seed) % 3) @(negedge clk);
                        tx_valid = 1'b1;
                        tx_data  = tx_byte(j, seed);
                        while (!tx_ready) @(negedge clk);
                        @(negedge clk);
                        acc++;
                        tx_valid = 1'b0;
                    end
                end
            end
            begin
                if (rd) begin
                    int k;
                    k = 0;
                    while (got < n) begin
                        @(negedge clk);
                        rx_ready = ((k * 7 + seed) % 3) != 0;
                        k++;
                        if (rx_valid && rx_ready) begin
                            rxq[got] = rx_data;
                            got++;
                        end
                    end
                    @(negedge clk);
                    rx_ready = 1'b0;
                end
            end
            begin
                if (!rd) begin
                    @(negedge cs_n);
                    chk(acc >= 1, "R6 first payload byte taken before cs_n falls", acc, 1);
                end
                @(posedge cs_n);
                chk(sclk == 1'b0, "R8 sclk low at chip select release", sclk, 0);
                @(negedge clk);
                chk(done == 1'b0 && busy == 1'b1, "R8 no done in release cycle", done, 0);
                @(negedge clk);
                chk(done == 1'b1 && busy == 1'b0, "R8 done with busy low", done, 1);
                @(negedge clk);
                chk(done == 1'b0, "R8 done lasts one cycle", done, 0);
            end
            begin
                if (poke) begin
                    repeat (6) @(negedge clk);
                    op_start = 1'b1;
                    op_code  = ~opc;
                    op_read  = ~rd;
                    op_addr_len = 3'(ab + 1);
                    @(negedge clk);
                    op_start = 1'b0;
                    op_code  = opc;
                    op_read  = rd;
                    op_addr_len = 3'(ab);
                end
            end
        join

        chk(bitpos - base == (hl + n) * 8, "R7 rising edge count of frame", bitpos - base, (hl + n) * 8);
        chk(cs_rises - c0 == 1, "R7 single chip select release", cs_rises - c0, 1);
        chk(done_cnt - d0 == 1, "R9 exactly one done per operation", done_cnt - d0, 1);
        chk(rise_t[base + 1] - rise_t[base] == longint'(2 * lim * CLK_PERIOD),
            "R4 sclk period", rise_t[base + 1] - rise_t[base], 2 * lim * CLK_PERIOD);

        hbad = 0;
        for (int i = 0; i < hl; i++) begin
            if (wire_byte(base, i) !== exp_hdr(i, opc, adr, abe)) begin
                hbad++;
                $display("FAIL R1 R2 R3 header byte %0d: actual %0h expected %0h",
                         i, wire_byte(base, i), exp_hdr(i, opc, adr, abe));
            end
        end
        chk(hbad == 0, (ab > 4 || db > 8) ? "R2 clamped header" : "R1 header bytes", hbad, 0);

        dbad = 0;
        for (int j = 0; j < n; j++) begin
            if (rd) begin
                if (wire_byte(base, hl + j) !== 8'h00) dbad++;
                if (j >= got || rxq[j] !== resp_byte(j, seed)) begin
                    dbad++;
                    if (j < got)
                        $display("FAIL R5 rx byte %0d: actual %0h expected %0h",
                                 j, rxq[j], resp_byte(j, seed));
                end
            end else begin
                if (wire_byte(base, hl + j) !== tx_byte(j, seed)) begin
                    dbad++;
                    $display("FAIL R6 tx byte %0d: actual %0h expected %0h",
                             j, wire_byte(base, hl + j), tx_byte(j, seed));
                end
            end
        end
        if (rd) begin
            chk(got == n, "R5 received byte count", got, n);
            chk(dbad == 0, (n > 256) ? "R10 long receive payload" : "R5 receive payload", dbad, 0);
        end else begin
            chk(dbad == 0, "R6 transmit payload", dbad, 0);
        end

        repeat (8) @(negedge clk);
        chk(busy == 1'b0 && cs_n == 1'b1 && sclk == 1'b0,
            poke ? "R9 idle after ignored start" : "R3 idle bus after operation",
            {busy, cs_n, sclk}, 3'b010);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1, "R7 reset cs_n high", cs_n, 1);
        chk(sclk == 1'b0, "R3 reset sclk low", sclk, 0);
        chk(busy == 1'b0 && done == 1'b0, "R8 reset busy and done low", {busy, done}, 0);
        chk(tx_ready == 1'b0, "R6 reset tx_ready low", tx_ready, 0);
        chk(rx_valid == 1'b0, "R5 reset rx_valid low", rx_valid, 0);

        for (int rd = 1; rd >= 0; rd--) begin
            for (int ab = 0; ab < 8; ab++) begin
                for (int di = 0; di < 4; di++) begin
                    int db;
                    db = (di == 0) ? 0 : (di == 1) ? 2 : (di == 2) ? 8 : 9;
                    run_op(rd[0], ab, db, (ab + di) % 4, (ab + di) % 3,
                           ab * 16 + di + rd * 100, (ab == 2 && di == 1) || (ab == 5 && di == 3));
                end
            end
        end

        run_op(1'b1, 3, 0, 300, 1, 77, 1'b0);
        run_op(1'b0, 4, 1, 40, 0, 91, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule